// File: doc/BRIEF.md
# Serial Audio Transmit Serializer

This block is the line side of an audio output controller. It runs from a master clock and drives three outputs: a bit clock, a word-select (left/right) clock and serial data, in standard two-channel I2S format with normal polarity. Both clocks come from this block, so the attached converter is a clock slave. The bit clock is the master clock divided by `2*(div_sel+2)`. With a master clock at 256 times the sample rate, `div_sel = 0` gives 32-bit stereo slots and `div_sel = 2` gives 16-bit stereo slots.

Samples come from an external FIFO through a show-ahead pop interface. Each 32-bit word holds one channel sample, and only its low `word_len` bits go out, most significant bit first. Each frame is a left slot followed by a right slot. When transmission is enabled, the block first sends one complete frame of zeros, starting on the left channel, and only then starts taking FIFO words. A slot that begins while the FIFO is empty carries zeros. Clearing the enable lets the current frame finish, after which the clocks stop and all outputs stay low.

Top module: `pcm_serial_tx`

## Requirements
- R1: Each half of the bit clock lasts `div_sel+2` master-clock cycles, so one bit period is `2*(div_sel+2)` cycles; `sclk_o` starts low when transmission begins.
- R2: After reset, and whenever the block is idle, `sclk_o`, `ws_o`, `sd_o` and `fifo_pop` are all low.
- R3: Once `tx_en` is seen high from idle, the first frame carries only zeros on `sd_o` and pops nothing, even when the FIFO holds data.
- R4: A slot is `L` bit periods long. `L` is `word_len`, except that 0 or any value above 32 means 32. The slot sends bits `L-1` down to 0 of its word, so the 32-`L` upper bits are never sent. `sd_o` only changes when `sclk_o` falls.
- R5: `ws_o` is 0 during the left slot and 1 during the right slot, and it leads the data by one bit period. It changes on the falling bit-clock edge one period before each slot's first bit, so in frame position `p` (0 to `2L-1`) it is 1 exactly when `L-1 <= p <= 2L-2`.
- R6: `fifo_pop` pulses for one cycle, in the cycle before a slot's first bit period begins, when the FIFO is not empty and that slot is not part of the zero frame. That cycle's `fifo_data` becomes the slot's word. A slot that begins with the FIFO empty sends zeros and pops nothing.
- R7: When `tx_en` is low at a frame boundary, the block stops there. No pop occurs, and the outputs are low from the next cycle. Enabling it again starts with a new zero frame.
- R8: `div_sel` and `word_len` are sampled only when transmission starts and at each frame boundary. A change in the middle of a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| div_sel | input | 8 | Bit-clock divider setting; half period is div_sel+2 master cycles |
| word_len | input | 6 | Slot length in bits, 1 to 32 (0 or above 32 means 32) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 32 | Head FIFO word (show-ahead) |
| fifo_pop | output | 1 | Consume the head FIFO word |
| sclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 for left, 1 for right |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The hardest situation to reach is a configuration change on the same master cycle as a frame boundary. In that case the new divider and slot length must take effect together with the first left bit, the word-select lead must be recomputed for the new length, and the final high half of the old bit clock must still be timed with the old divider. The stimulus changes `div_sel` and `word_len` partway through running frames, including a move to one-bit slots, where word select toggles on every bit. It also clears `tx_en` partway through a frame, so the stop must wait for the boundary. FIFO underruns are produced by queuing fewer words than the frames consume, so that slots which find the FIFO empty and the zero frame after a restart are both covered.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  // Word select for frame position pos with slot length len: high one bit
  // period before the right slot up to one period before the frame ends.
  function automatic logic ws_for(input int pos, input int len);
    return ((pos + 1) >= len) && ((pos + 2) <= (2 * len));
  endfunction

endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             sclk,
  output logic             fall_tick
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             term;

  // half period = div_q + 2 cycles: count 0 .. div_q+1
  assign term = (cnt_q == ({1'b0, div_q} + CNT_W'(1)));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (term) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign fall_tick = run & term & sclk_q;

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RES_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [DIV_W-1:0] div_in,
  input  logic [RES_W-1:0] len_in,
  input  logic             fall_tick,
  input  logic             fifo_empty,
  output logic             running,
  output logic [DIV_W-1:0] div_q,
  output logic [RES_W-1:0] len_use,
  output logic             ws_o,
  output logic             adv,
  output logic             halt,
  output logic             load,
  output logic             pop,
  output logic             zero_frm
);

  localparam int POS_W = RES_W + 1;
  localparam logic [RES_W-1:0] FULL_LEN = RES_W'(WORD_W);

  run_state_t       st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [RES_W-1:0] len_q, len_d, len_new;
  logic [DIV_W-1:0] div_d;
  logic             ws_q, ws_d, zero_q, zero_d;
  logic             start, bnd, last, mid, cfg_en;

  assign len_new = ((len_in == '0) || (len_in > FULL_LEN)) ? FULL_LEN : len_in;
  assign last    = (pos_q == ({len_q, 1'b0} - POS_W'(1)));
  assign mid     = (pos_q == ({1'b0, len_q} - POS_W'(1)));

  assign start   = (st_q == ST_IDLE) && tx_en;
  assign adv     = (st_q == ST_RUN) && fall_tick;
  assign bnd     = adv && last;
  assign halt    = bnd && !tx_en;
  assign cfg_en  = start || bnd;
  assign len_use = cfg_en ? len_new : len_q;
  assign zero_d  = start ? 1'b1 : (bnd ? 1'b0 : zero_q);
  assign load    = start || (bnd && tx_en) || (adv && !last && mid);
  assign pop     = load && !fifo_empty && !zero_d;

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    ws_d  = ws_q;
    len_d = cfg_en ? len_new : len_q;
    div_d = cfg_en ? div_in : div_q;
    if (start) begin
      st_d  = ST_RUN;
      pos_d = '0;
    end else if (halt) begin
      st_d  = ST_IDLE;
      pos_d = '0;
    end else if (bnd) begin
      pos_d = '0;
    end else if (adv) begin
      pos_d = pos_q + POS_W'(1);
    end
    if (halt)                ws_d = 1'b0;
    else if (start || adv)   ws_d = ws_for(int'(pos_d), int'(len_use));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      len_q  <= FULL_LEN;
      div_q  <= '0;
      ws_q   <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      len_q  <= len_d;
      div_q  <= div_d;
      ws_q   <= ws_d;
      zero_q <= zero_d;
    end
  end

  assign running  = (st_q == ST_RUN);
  assign ws_o     = ws_q;
  assign zero_frm = zero_q;

endmodule

// File: rtl/pcm_shift_out.sv
module pcm_shift_out #(
  parameter int WORD_W = 32,
  parameter int RES_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              pop,
  input  logic              adv,
  input  logic              halt,
  input  logic [WORD_W-1:0] word,
  input  logic [RES_W-1:0]  len_use,
  output logic              sd
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [RES_W-1:0]  lsh;

  // left-align the low len_use bits so the slot MSB sits at the top
  assign lsh = RES_W'(WORD_W) - len_use;

  always_comb begin
    sh_d = sh_q;
    if (halt)      sh_d = '0;
    else if (load) sh_d = pop ? (word << lsh) : '0;
    else if (adv)  sh_d = {sh_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sd = sh_q[WORD_W-1];

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RES_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [RES_W-1:0]  word_len,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              sclk_o,
  output logic              ws_o,
  output logic              sd_o
);

  logic             rst_i_n;
  logic             running, fall_tick, adv, halt, load, pop, zero_frm;
  logic [DIV_W-1:0] div_q;
  logic [RES_W-1:0] len_use;

  pcm_rst_sync u_rst (
    .clk(mclk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pcm_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(mclk), .rst_n(rst_i_n), .run(running), .div_q(div_q),
    .sclk(sclk_o), .fall_tick(fall_tick)
  );

  pcm_frame_seq #(.WORD_W(WORD_W), .RES_W(RES_W), .DIV_W(DIV_W)) u_seq (
    .clk(mclk), .rst_n(rst_i_n), .tx_en(tx_en), .div_in(div_sel),
    .len_in(word_len), .fall_tick(fall_tick), .fifo_empty(fifo_empty),
    .running(running), .div_q(div_q), .len_use(len_use), .ws_o(ws_o),
    .adv(adv), .halt(halt), .load(load), .pop(pop), .zero_frm(zero_frm)
  );

  pcm_shift_out #(.WORD_W(WORD_W), .RES_W(RES_W)) u_shift (
    .clk(mclk), .rst_n(rst_i_n), .load(load), .pop(pop), .adv(adv),
    .halt(halt), .word(fifo_data), .len_use(len_use), .sd(sd_o)
  );

  assign fifo_pop = pop;

endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             zero_frm,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             sclk_o,
  input logic             ws_o,
  input logic             sd_o,
  input logic [DIV_W-1:0] div_q
);

  localparam int HC_W = DIV_W + 2;

  logic            prev_s;
  logic [HC_W-1:0] hc;

  // cycles the bit clock has held its level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= 1'b0;
      hc     <= '0;
    end else begin
      prev_s <= sclk_o;
      if (!running)              hc <= '0;
      else if (sclk_o != prev_s) hc <= HC_W'(1);
      else                       hc <= hc + HC_W'(1);
    end
  end

  a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (sclk_o != prev_s))
      |-> (hc == ({2'b00, $past(div_q)} + HC_W'(2))));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!sclk_o && !ws_o && !sd_o && !fifo_pop));

  a_r3_zero_frame_silent: assert property (@(posedge clk) disable iff (!rst_n)
    zero_frm |-> !sd_o);

  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sd_o));

  a_r5_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(ws_o));

  a_r6_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  a_r6_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(mclk), .rst_n(rst_n), .running(running), .zero_frm(zero_frm),
  .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .sclk_o(sclk_o),
  .ws_o(ws_o), .sd_o(sd_o), .div_q(div_q)
);

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;

  logic        mclk = 1'b0;
  logic        rst_n, tx_en, fifo_empty;
  logic [7:0]  div_sel;
  logic [5:0]  word_len;
  logic [31:0] fifo_data;
  logic        fifo_pop, sclk_o, ws_o, sd_o;

  int checks = 0;
  int errors = 0;
  int pop_cnt = 0;
  bit done = 1'b0;

  logic [31:0] fq[$];
  logic [31:0] mq[$];

  always #2 mclk = ~mclk;

  pcm_serial_tx i_pcm_serial_tx (
    .mclk(mclk), .rst_n(rst_n), .tx_en(tx_en), .div_sel(div_sel),
    .word_len(word_len), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  function automatic int eff_len(input int r);
    return (r == 0 || r > 32) ? 32 : r;
  endfunction

  function automatic logic [31:0] lowbits(input logic [31:0] w, input int r);
    return (r >= 32) ? w : (w & ((32'h1 << r) - 32'h1));
  endfunction

  // FIFO model feeding the design
  always @(posedge mclk) begin
    if (rst_n && fifo_pop) begin
      pop_cnt++;
      if (fq.size() > 0) void'(fq.pop_front());
      fifo_empty <= (fq.size() == 0);
      fifo_data  <= (fq.size() > 0) ? fq[0] : 32'h0;
    end
  end

  task automatic push(input logic [31:0] w);
    fq.push_back(w);
    mq.push_back(w);
    fifo_empty = 1'b0;
    fifo_data  = fq[0];
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge mclk);
    #1;
  endtask

  // behavioural reference, compared every cycle
  bit          m_run = 1'b0;
  bit          m_zero = 1'b0;
  int          m_t = 0, mL = 32, mD = 0, mP = 4;
  logic [31:0] m_word = 32'h0;

  always @(negedge mclk) begin : ref_model
    int p, j, nt;
    logic e_b, e_w, e_s, e_p;
    if (!rst_n) begin
      m_run = 1'b0;
    end else begin
      e_b = 1'b0; e_w = 1'b0; e_s = 1'b0; e_p = 1'b0; nt = 0;
      if (m_run) begin
        p   = m_t / mP;
        e_b = (m_t % mP) >= (mD + 2);
        e_w = (p >= mL - 1) && (p <= 2 * mL - 2);
        j   = (p < mL) ? (mL - 1 - p) : (2 * mL - 1 - p);
        e_s = m_word[j];
        nt  = m_t + 1;
        if (nt == 2 * mL * mP)  e_p = tx_en && (mq.size() > 0);
        else if (nt == mL * mP) e_p = !m_zero && (mq.size() > 0);
        chk("R1", "sclk", int'(sclk_o), int'(e_b));
        chk("R5", "ws", int'(ws_o), int'(e_w));
        chk(m_zero ? "R3" : "R4", "sd", int'(sd_o), int'(e_s));
        chk("R6", "pop", int'(fifo_pop), int'(e_p));
      end else begin
        chk("R2", "idle sclk", int'(sclk_o), 0);
        chk("R2", "idle ws", int'(ws_o), 0);
        chk("R2", "idle sd", int'(sd_o), 0);
        chk("R2", "idle pop", int'(fifo_pop), 0);
      end
      // next state
      if (!m_run) begin
        if (tx_en) begin
          m_run = 1'b1; m_t = 0; m_zero = 1'b1; m_word = 32'h0;
          mL = eff_len(int'(word_len)); mD = int'(div_sel); mP = 2 * (mD + 2);
        end
      end else if (nt == 2 * mL * mP) begin
        if (!tx_en) begin
          m_run = 1'b0;
        end else begin  // R8: settings taken at the boundary
          mL = eff_len(int'(word_len)); mD = int'(div_sel); mP = 2 * (mD + 2);
          m_zero = 1'b0; m_t = 0;
          m_word = e_p ? lowbits(mq.pop_front(), mL) : 32'h0;
        end
      end else if (nt == mL * mP) begin
        m_word = e_p ? lowbits(mq.pop_front(), mL) : 32'h0;
        m_t = nt;
      end else begin
        m_t = nt;
      end
    end
  end

  task automatic meas_period(output int per);
    int n;
    n = 0;
    @(negedge mclk);
    while (!sclk_o) @(negedge mclk);
    while (sclk_o)  @(negedge mclk);
    while (!sclk_o) begin n++; @(negedge mclk); end
    while (sclk_o)  begin n++; @(negedge mclk); end
    per = n;
    step(1);
  endtask

  task automatic idle_outputs(input string tag);
    chk(tag, "sclk low", int'(sclk_o), 0);
    chk(tag, "ws low", int'(ws_o), 0);
    chk(tag, "sd low", int'(sd_o), 0);
  endtask

  initial begin : stim
    int per, base;
    rst_n = 1'b0; tx_en = 1'b0; div_sel = 8'd0; word_len = 6'd16;
    fifo_empty = 1'b1; fifo_data = 32'h0;
    step(4);
    rst_n = 1'b1;
    step(4);
    idle_outputs("R2");
    chk("R2", "no pop after reset", pop_cnt, 0);

    // 16-bit slots, divider 2
    div_sel = 8'd2; word_len = 6'd16;
    push(32'hDEAD_1234); push(32'hBEEF_8001); push(32'h0000_F00F);
    push(32'h5555_AAAA); push(32'hFFFF_0FF0);
    tx_en = 1'b1;
    base = pop_cnt;
    step(250);
    chk("R3", "pops during zero frame", pop_cnt - base, 0);
    meas_period(per);
    chk("R1", "bit period div 2", per, 8);
    step(800);
    chk("R6", "words consumed", pop_cnt - base, 5);
    chk("R6", "fifo drained", fq.size(), 0);
    tx_en = 1'b0;
    step(300);
    idle_outputs("R7");
    base = pop_cnt;
    step(50);
    chk("R7", "no pop when stopped", pop_cnt - base, 0);

    // length 0 means 32, divider 0 then 1 mid-frame
    div_sel = 8'd0; word_len = 6'd0;
    push(32'h8000_0001); push(32'h1234_5678); push(32'hCAFE_F00D); push(32'h0F0F_0F0F);
    tx_en = 1'b1;
    step(60);
    meas_period(per);
    chk("R1", "bit period div 0", per, 4);
    step(230);
    div_sel = 8'd1;   // R8: applies from the next frame
    step(300);
    meas_period(per);
    chk("R8", "bit period after boundary", per, 6);
    tx_en = 1'b0;
    step(500);
    idle_outputs("R7");
    chk("R4", "32-bit words consumed", fq.size(), 0);

    // 5-bit slots with high bits set, then 1-bit slots, restart
    div_sel = 8'd1; word_len = 6'd5;
    for (int k = 0; k < 8; k++) push(32'hFFFF_FFE0 | 32'(k * 3));
    tx_en = 1'b1;
    base = pop_cnt;
    step(55);
    chk("R3", "restart zero frame", pop_cnt - base, 0);
    step(150);
    word_len = 6'd1;
    step(100);
    tx_en = 1'b0;
    step(80);
    idle_outputs("R7");
    word_len = 6'd40;
    tx_en = 1'b1;
    step(400);
    tx_en = 1'b0;
    step(600);
    idle_outputs("R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge mclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule